// File: doc/BRIEF.md
# Multi-Mode Host Bus Interface

This block is the slave end of a host processor bus. It turns host cycles into single-clock accesses on a small internal register port. The register port covers a window of 16 I/O locations plus one 32-bit data port. Three kinds of host cycle are accepted:

- asynchronous cycles, timed by read and write strobes and answered through a ready output;
- local-bus synchronous cycles, started by an address strobe and a cycle signal, with wait states that either side can insert;
- synchronous burst cycles, which use a data select line and move one 32-bit word per beat.

The block decodes the address against a configured base, with an optional address hold. It maps the active-low byte enables onto internal lanes. It can also exchange the two 16-bit halves of the data under a static configuration bit. The block runs entirely on `clk_i`, which is the host bus clock. The asynchronous strobes are brought into that clock domain by a synchronizer. Only the ready output reacts to them directly.

Top module: `host_bus_if`

## Requirements
- R1: While `rst_ni` is low: `sync_rdy_no` is 1, `async_rdy_o` is 1 with no strobe active, and `reg_wr_o`, `reg_rd_o` and `rdata_oe_o` are 0.
- R2: A register access is selected only when both hold: the effective address bits [15:4] equal `cfg_base_i`, and `addr_gate_i` is 0. The internal index `reg_idx_o` is then the effective address bits [3:0]. An unselected cycle produces no internal strobe, and it leaves both ready outputs released (high).
- R3: While `dsel_ni` is 0, the address and `be_ni` are ignored. The access goes to the data port: `reg_dport_o` is 1, `reg_idx_o` is 0 and `reg_be_o` is 4'hF.
- R4: The effective address follows `addr_i` while `addr_strb_ni` is 0. While `addr_strb_ni` is 1, it holds the value `addr_i` had at the last clock edge on which `addr_strb_ni` was 0.
- R5: With swapping off, `reg_be_o[i]` equals `~be_ni[i]`. Lane i is data bits [8i+7:8i]. `reg_wdata_o` equals `wdata_i` captured when the access starts.
- R6: With `cfg_swap_i` set, three things change:
  - the two 16-bit halves of the write data are exchanged;
  - the lane enables become `{be[1:0], be[3:2]}`;
  - `rdata_o` is the read data with its halves exchanged.
  Bytes inside each half keep their order.
- R7: In asynchronous mode, `async_rdy_o` falls as soon as `rd_ni` or `wr_ni` goes low on a selected access. It rises once the write has been issued or the read data is held on `rdata_o`, and at that point `rdata_oe_o` is 1 for a read. Each strobe assertion yields exactly one internal access.
- R8: With `burst_mode_i` = 0, a synchronous access starts on the edge where `cycle_ni` = 0, `addr_strb_ni` = 0 and the access is selected. The internal strobe appears in the next cycle. `sync_rdy_no` goes low when the write is issued or the read data has arrived.
- R9: While `sync_rdy_no` is 0 and `host_rdy_ni` is 1, `sync_rdy_no` stays 0 and `rdata_o` stays stable. One cycle after `host_rdy_ni` is sampled 0, `sync_rdy_no` returns to 1.
- R10: With `burst_mode_i` = 1, every beat is one 32-bit data-port transfer while `cycle_ni` and `dsel_ni` stay 0. Beats follow one another without any address strobe.
- R11: Each internal strobe lasts one clock, and `reg_wr_o` and `reg_rd_o` are never high together. A read completes on `reg_rvalid_i`, whatever its latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | 12 | Base compared with address bits [15:4] |
| cfg_swap_i | input | 1 | Static 16-bit half exchange enable |
| burst_mode_i | input | 1 | 0: local-bus synchronous cycles, 1: burst cycles |
| addr_i | input | 16 | Host address |
| addr_gate_i | input | 1 | High blocks address decode |
| addr_strb_ni | input | 1 | Address strobe, active low |
| be_ni | input | 4 | Byte enables, active low |
| dsel_ni | input | 1 | Data port select, active low |
| wdata_i | input | 32 | Host write data |
| rdata_o | output | 32 | Host read data |
| rdata_oe_o | output | 1 | Read data valid toward host |
| rd_ni | input | 1 | Asynchronous read strobe, active low |
| wr_ni | input | 1 | Asynchronous write strobe, active low |
| async_rdy_o | output | 1 | Asynchronous ready, low while busy |
| cycle_ni | input | 1 | Synchronous cycle active, active low |
| sync_wr_i | input | 1 | Synchronous direction, 1 = write |
| sync_rdy_no | output | 1 | Synchronous ready from the block, active low |
| host_rdy_ni | input | 1 | Host ready return, active low |
| reg_idx_o | output | 4 | Internal register index |
| reg_be_o | output | 4 | Internal lane enables, active high |
| reg_wdata_o | output | 32 | Internal write data |
| reg_wr_o | output | 1 | Internal write strobe |
| reg_rd_o | output | 1 | Internal read strobe |
| reg_dport_o | output | 1 | Access targets the data port |
| reg_rvalid_i | input | 1 | Internal read data valid |
| reg_rdata_i | input | 32 | Internal read data |

## Verification
The properties assume four things about the inputs:
- synchronous and asynchronous cycles never overlap;
- `reg_rvalid_i` arrives only in answer to an outstanding read;
- address, data and byte enables stay steady while a strobe is low;
- the configuration inputs change only while the block is idle.

The stimulus drives every host cycle from one sequential task at a time. It changes the configuration only between cycles, and it waits several clocks after each release so that the synchronized strobes settle. The register model in the bench answers only reads it has seen, after one cycle for registers and three for the data port.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_RD = 2'd1,
    ST_ACK     = 2'd2
  } hbi_state_e;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '1;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbi_decode.sv
module hbi_decode #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 4,
  localparam int BASE_W = ADDR_W - SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_strb_ni,
  input  logic              addr_gate_i,
  input  logic              dsel_ni,
  input  logic [BASE_W-1:0] base_i,
  output logic [SEL_W-1:0]  idx_o,
  output logic              sel_o,
  output logic              dport_o
);
  logic [ADDR_W-1:0] addr_q, addr_eff;
  logic              hit;

  // hold register: follows while strobe low, keeps last value after rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            addr_q <= '0;
    else if (!addr_strb_ni) addr_q <= addr_i;
  end

  assign addr_eff = addr_strb_ni ? addr_q : addr_i;
  assign hit      = (addr_eff[ADDR_W-1:SEL_W] == base_i) && !addr_gate_i;
  assign dport_o  = !dsel_ni;
  assign sel_o    = dport_o || hit;
  assign idx_o    = dport_o ? '0 : addr_eff[SEL_W-1:0];
endmodule

// File: rtl/hbi_swap.sv
module hbi_swap #(
  parameter int W = 32,
  localparam int H = W / 2
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < H; i++) begin : g_half
    assign q_o[i]   = en_i ? d_i[i+H] : d_i[i];
    assign q_o[i+H] = en_i ? d_i[i]   : d_i[i+H];
  end
endmodule

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
  import hbi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_s_i,
  input  logic              wr_s_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              burst_mode_i,
  input  logic              cycle_ni,
  input  logic              addr_strb_ni,
  input  logic              sync_wr_i,
  input  logic              host_rdy_ni,
  input  logic              sel_i,
  input  logic              dport_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              reg_rvalid_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [BE_W-1:0]   reg_be_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic              reg_dport_o,
  output logic              sync_rdy_no,
  output logic              async_rdy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  hbi_state_e state_q;
  logic       cur_async_q, cur_rd_q;
  logic       sync_go, async_go, start_wr, ack_async;

  assign sync_go  = !cycle_ni && (burst_mode_i ? dport_i : (!addr_strb_ni && sel_i));
  assign async_go = (!rd_s_i || !wr_s_i) && sel_i;
  assign start_wr = sync_go ? sync_wr_i : !wr_s_i;
  assign ack_async = (state_q == ST_ACK) && cur_async_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_async_q <= 1'b0;
      cur_rd_q    <= 1'b0;
      reg_idx_o   <= '0;
      reg_be_o    <= '0;
      reg_wdata_o <= '0;
      reg_wr_o    <= 1'b0;
      reg_rd_o    <= 1'b0;
      reg_dport_o <= 1'b0;
      rdata_o     <= '0;
    end else begin
      reg_wr_o <= 1'b0;
      reg_rd_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (sync_go || async_go) begin
            cur_async_q <= !sync_go;
            cur_rd_q    <= !start_wr;
            reg_idx_o   <= idx_i;
            reg_be_o    <= be_i;
            reg_wdata_o <= wdata_i;
            reg_dport_o <= dport_i;
            if (start_wr) begin
              reg_wr_o <= 1'b1;
              state_q  <= ST_ACK;
            end else begin
              reg_rd_o <= 1'b1;
              state_q  <= ST_WAIT_RD;
            end
          end
        end
        ST_WAIT_RD: begin
          if (reg_rvalid_i) begin
            rdata_o <= reg_rdata_i;
            state_q <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (cur_async_q ? (rd_s_i && wr_s_i) : !host_rdy_ni) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sync_rdy_no = !((state_q == ST_ACK) && !cur_async_q);
  // combinational from the raw strobe so ready drops on the leading edge
  assign async_rdy_o = !((!rd_ni || !wr_ni) && sel_i && !ack_async);
  assign rdata_oe_o  = (state_q == ST_ACK) && cur_rd_q;
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if #(
  parameter int ADDR_W      = 16,
  parameter int SEL_W       = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int BASE_W = ADDR_W - SEL_W,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BASE_W-1:0] cfg_base_i,
  input  logic              cfg_swap_i,
  input  logic              burst_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_gate_i,
  input  logic              addr_strb_ni,
  input  logic [BE_W-1:0]   be_ni,
  input  logic              dsel_ni,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output logic              async_rdy_o,
  input  logic              cycle_ni,
  input  logic              sync_wr_i,
  output logic              sync_rdy_no,
  input  logic              host_rdy_ni,
  output logic [SEL_W-1:0]  reg_idx_o,
  output logic [BE_W-1:0]   reg_be_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic              reg_dport_o,
  input  logic              reg_rvalid_i,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic [1:0]        strb_s;
  logic [SEL_W-1:0]  dec_idx;
  logic              dec_sel, dec_dport;
  logic [BE_W-1:0]   be_act, be_sw;
  logic [DATA_W-1:0] wdata_sw, rdata_int;

  hbi_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rd_ni, wr_ni}),
    .q_o   (strb_s)
  );

  hbi_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .addr_strb_ni(addr_strb_ni),
    .addr_gate_i (addr_gate_i),
    .dsel_ni     (dsel_ni),
    .base_i      (cfg_base_i),
    .idx_o       (dec_idx),
    .sel_o       (dec_sel),
    .dport_o     (dec_dport)
  );

  // data port always moves a full word
  assign be_act = dec_dport ? '1 : ~be_ni;

  hbi_swap #(.W(BE_W))   u_swap_be (.en_i(cfg_swap_i), .d_i(be_act),    .q_o(be_sw));
  hbi_swap #(.W(DATA_W)) u_swap_wd (.en_i(cfg_swap_i), .d_i(wdata_i),   .q_o(wdata_sw));
  hbi_swap #(.W(DATA_W)) u_swap_rd (.en_i(cfg_swap_i), .d_i(rdata_int), .q_o(rdata_o));

  hbi_ctrl #(.DATA_W(DATA_W), .BE_W(BE_W), .IDX_W(SEL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_s_i      (strb_s[1]),
    .wr_s_i      (strb_s[0]),
    .rd_ni       (rd_ni),
    .wr_ni       (wr_ni),
    .burst_mode_i(burst_mode_i),
    .cycle_ni    (cycle_ni),
    .addr_strb_ni(addr_strb_ni),
    .sync_wr_i   (sync_wr_i),
    .host_rdy_ni (host_rdy_ni),
    .sel_i       (dec_sel),
    .dport_i     (dec_dport),
    .idx_i       (dec_idx),
    .be_i        (be_sw),
    .wdata_i     (wdata_sw),
    .reg_rvalid_i(reg_rvalid_i),
    .reg_rdata_i (reg_rdata_i),
    .reg_idx_o   (reg_idx_o),
    .reg_be_o    (reg_be_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_wr_o    (reg_wr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_dport_o (reg_dport_o),
    .sync_rdy_no (sync_rdy_no),
    .async_rdy_o (async_rdy_o),
    .rdata_o     (rdata_int),
    .rdata_oe_o  (rdata_oe_o)
  );
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_rdy_no,
  input logic              host_rdy_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              reg_wr_o,
  input logic              reg_rd_o,
  input logic              reg_dport_o,
  input logic [BE_W-1:0]   reg_be_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (sync_rdy_no && !reg_wr_o && !reg_rd_o)
        else $error("reset state violated");
    end
  end

  a_r11_no_dual_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o));

  a_r11_wr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  a_r11_rd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);

  a_r3_dport_full_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_dport_o && (reg_wr_o || reg_rd_o)) |-> (reg_be_o == '1));

  a_r9_hold_while_stretched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_rdy_no && host_rdy_ni) |=> (!sync_rdy_no && $stable(rdata_o)));

  a_r9_release_after_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_rdy_no && !host_rdy_ni) |=> sync_rdy_no);
endmodule

bind host_bus_if hbi_checker #(.DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sync_rdy_no(sync_rdy_no),
  .host_rdy_ni(host_rdy_ni),
  .rdata_o    (rdata_o),
  .reg_wr_o   (reg_wr_o),
  .reg_rd_o   (reg_rd_o),
  .reg_dport_o(reg_dport_o),
  .reg_be_o   (reg_be_o)
);

// File: tb/host_bus_if_tb.sv
module host_bus_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] BASE = 12'h3A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [11:0] cfg_base = BASE;
  logic        swap = 1'b0, burst = 1'b0;
  logic [15:0] addr = '0;
  logic        gate = 1'b0, strb_n = 1'b1, dsel_n = 1'b1;
  logic [3:0]  be_n = 4'hF;
  logic [31:0] wdata = '0, rdata;
  logic        rdata_oe, rd_n = 1'b1, wr_n = 1'b1, ardy;
  logic        cyc_n = 1'b1, swr = 1'b0, srdy_n, hrdy_n = 1'b1;
  logic [3:0]  ridx, rbe;
  logic [31:0] rwdata, rrdata = '0;
  logic        rwr, rrd, rdp, rvalid = 1'b0;

  int n_chk = 0, n_bad = 0, dcnt = 0;
  logic [31:0] last_rsp = '0;
  logic [41:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  host_bus_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_base_i(cfg_base), .cfg_swap_i(swap),
    .burst_mode_i(burst), .addr_i(addr), .addr_gate_i(gate), .addr_strb_ni(strb_n),
    .be_ni(be_n), .dsel_ni(dsel_n), .wdata_i(wdata), .rdata_o(rdata),
    .rdata_oe_o(rdata_oe), .rd_ni(rd_n), .wr_ni(wr_n), .async_rdy_o(ardy),
    .cycle_ni(cyc_n), .sync_wr_i(swr), .sync_rdy_no(srdy_n), .host_rdy_ni(hrdy_n),
    .reg_idx_o(ridx), .reg_be_o(rbe), .reg_wdata_o(rwdata), .reg_wr_o(rwr),
    .reg_rd_o(rrd), .reg_dport_o(rdp), .reg_rvalid_i(rvalid), .reg_rdata_i(rrdata)
  );

  task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [31:0] hview(input logic [31:0] x);
    return swap ? {x[15:0], x[31:16]} : x;
  endfunction

  // expected internal access: {wr, dport, idx, lanes, wdata}
  function automatic logic [41:0] mk_txn(input bit wr, input bit dp, input logic [3:0] idx,
                                         input logic [3:0] ben, input logic [31:0] d);
    logic [3:0]  be;
    logic [31:0] dd;
    be = dp ? 4'hF : ~ben;
    dd = d;
    if (swap) begin
      be = {be[1:0], be[3:2]};
      dd = {d[15:0], d[31:16]};
    end
    return {wr, dp, dp ? 4'h0 : idx, be, wr ? dd : 32'h0};
  endfunction

  // reference monitor: every clock, an internal strobe must match the next expected access
  initial forever begin
    @(negedge clk);
    if (rst_n && (rwr || rrd)) begin
      if (expq.size() == 0) begin
        check_eq("R2/R11 unexpected internal access", {rwr, rdp, ridx, rbe, 32'h0}, 64'h0);
      end else begin
        check_eq("R2/R3/R5/R6 internal access", {rwr, rdp, ridx, rbe, rwr ? rwdata : 32'h0},
                 expq.pop_front());
      end
    end
  end

  // register model: one cycle for registers, three for the data port
  initial forever begin
    @(negedge clk);
    if (rst_n && rrd) begin
      logic [31:0] rsp;
      if (rdp) begin
        repeat (2) @(negedge clk);
        rsp = 32'hDA7A_0000 + dcnt;
        dcnt++;
      end else begin
        rsp = {16'hC0DE, 8'h5A, 4'h0, ridx};
      end
      rvalid = 1'b1;
      rrdata = rsp;
      last_rsp = rsp;
      @(negedge clk);
      rvalid = 1'b0;
    end
  end

  task automatic async_acc(input bit wr, input logic [15:0] a, input logic [3:0] ben,
                           input logic [31:0] d, input bit dsel, input bit hit, input string req);
    int t;
    @(negedge clk);
    addr = a; be_n = ben; wdata = d; dsel_n = !dsel; strb_n = 1'b0;
    if (hit) expq.push_back(mk_txn(wr, dsel, a[3:0], ben, d));
    if (wr) wr_n = 1'b0; else rd_n = 1'b0;
    #1 check_eq({req, " R7 ready at leading edge"}, ardy, !hit);
    if (hit) begin
      t = 0;
      while (!ardy && t < 40) begin @(negedge clk); t++; end
      check_eq({req, " R7 ready returns"}, ardy, 1);
      if (!wr) begin
        check_eq({req, " R7 read data"}, rdata, hview(last_rsp));
        check_eq({req, " R7 data enable"}, rdata_oe, 1);
      end
    end else begin
      repeat (8) @(negedge clk);
      check_eq({req, " R2 ready stays released"}, ardy, 1);
    end
    wr_n = 1'b1; rd_n = 1'b1; strb_n = 1'b1; dsel_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic sync_acc(input bit wr, input logic [15:0] a, input logic [3:0] ben,
                          input logic [31:0] d, input bit hit, input int stretch, input string req);
    int t;
    logic [31:0] r0;
    @(negedge clk);
    addr = a; be_n = ben; wdata = d; swr = wr; strb_n = 1'b0; cyc_n = 1'b0;
    if (hit) expq.push_back(mk_txn(wr, 1'b0, a[3:0], ben, d));
    @(negedge clk);
    strb_n = 1'b1;
    if (!hit) begin
      repeat (6) @(negedge clk);
      check_eq({req, " R2 no sync ready"}, srdy_n, 1);
      cyc_n = 1'b1;
      repeat (2) @(negedge clk);
      return;
    end
    t = 0;
    while (srdy_n && t < 40) begin @(negedge clk); t++; end
    check_eq({req, " R8 sync ready low"}, srdy_n, 0);
    r0 = rdata;
    if (!wr) check_eq({req, " R8 read data"}, rdata, hview(last_rsp));
    for (int i = 0; i < stretch; i++) begin
      @(negedge clk);
      check_eq({req, " R9 held while stretched"}, {srdy_n, rdata}, {1'b0, r0});
    end
    hrdy_n = 1'b0; cyc_n = 1'b1;
    @(negedge clk);
    hrdy_n = 1'b1;
    check_eq({req, " R9 released after return"}, srdy_n, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic burst_acc(input bit wr, input int beats, input logic [31:0] d0, input string req);
    int t;
    @(negedge clk);
    addr = 16'hFFFF; be_n = 4'b1010; wdata = d0; swr = wr; dsel_n = 1'b0; cyc_n = 1'b0;
    for (int i = 0; i < beats; i++) begin
      expq.push_back(mk_txn(wr, 1'b1, 4'h0, 4'b1010, d0 + i));
      t = 0;
      while (srdy_n && t < 40) begin @(negedge clk); t++; end
      check_eq({req, " R10 beat ready"}, srdy_n, 0);
      if (!wr) check_eq({req, " R10/R11 beat read data"}, rdata, hview(last_rsp));
      hrdy_n = 1'b0;
      if (i == beats - 1) begin cyc_n = 1'b1; dsel_n = 1'b1; end
      else wdata = d0 + i + 1;
      @(negedge clk);
      hrdy_n = 1'b1;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 reset outputs", {srdy_n, ardy, rwr, rrd, rdata_oe}, 5'b11000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // asynchronous cycles, lanes 0 and 1 enabled
    async_acc(1, {BASE, 4'h6}, 4'b1100, 32'hA1B2_C3D4, 0, 1, "R5 async write");
    async_acc(0, {BASE, 4'h9}, 4'b0000, 32'h0, 0, 1, "R7 async read");
    async_acc(1, {12'h3A4, 4'h2}, 4'b0000, 32'h1111_2222, 0, 0, "R2 wrong base");
    gate = 1'b1;
    async_acc(1, {BASE, 4'h2}, 4'b0000, 32'h3333_4444, 0, 0, "R2 gated");
    gate = 1'b0;

    // address hold after strobe rise
    @(negedge clk);
    addr = {BASE, 4'hC}; strb_n = 1'b0; be_n = 4'b0011; wdata = 32'h0BAD_F00D;
    @(negedge clk);
    strb_n = 1'b1; addr = 16'h0001;
    expq.push_back(mk_txn(1, 0, 4'hC, 4'b0011, 32'h0BAD_F00D));
    wr_n = 1'b0;
    #1 check_eq("R4 held address selects", ardy, 0);
    repeat (6) @(negedge clk);
    check_eq("R4 held address access done", ardy, 1);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);

    // half exchange
    swap = 1'b1;
    async_acc(1, {BASE, 4'h4}, 4'b1110, 32'h1122_3344, 0, 1, "R6 swapped write");
    async_acc(0, {BASE, 4'h5}, 4'b0000, 32'h0, 0, 1, "R6 swapped read");
    swap = 1'b0;

    // data select overrides decode and lanes
    async_acc(1, 16'h0123, 4'b0101, 32'hFEED_BEEF, 1, 1, "R3 async data port");

    // local-bus synchronous cycles
    sync_acc(1, {BASE, 4'h3}, 4'b0000, 32'h5566_7788, 1, 3, "R8 sync write");
    sync_acc(0, {BASE, 4'hA}, 4'b1001, 32'h0, 1, 4, "R9 sync read");
    sync_acc(1, {12'h001, 4'h3}, 4'b0000, 32'h9999_0000, 0, 0, "R2 sync miss");

    // burst cycles
    burst = 1'b1;
    burst_acc(1, 4, 32'h1000_0000, "R10 burst write");
    swap = 1'b1;
    burst_acc(0, 3, 32'h0, "R10 burst read");
    swap = 1'b0;
    burst = 1'b0;

    repeat (5) @(negedge clk);
    check_eq("R11 all expected accesses seen", expq.size(), 0);
    summary();
    $finish;
  end
endmodule